// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Three-Bit Instruction Decode

This block is the serial test port of a memory device. It is clocked by the test clock. A mode-select line walks a sixteen-state controller through its data-side and instruction-side scan sequences. A serial data line feeds whichever register the current instruction places between the port's input and output. The block holds a three-bit instruction register, a one-bit bypass stage and a 32-bit identity register. It also controls an external boundary-scan chain through capture, shift and update strobes, and it takes that chain's serial output back in.

There is no test-reset pin. A power-up reset places the controller in its reset state, and five rising clock edges with the mode line high bring it back there from any state. The instruction decode raises a flag while the external-test instruction is active. It also raises a request for the device's data outputs to go high-impedance while the sample-with-float instruction is active, so that the inputs can be observed undisturbed. The serial output changes on the falling clock edge and is enabled only while a register is being shifted.

Top module: `tap_top`

## Requirements
- R1: While and after power-up reset (`pwr_rst_n` low), the controller is in Test-Logic-Reset, the active instruction is 001 (identity), `tdo_oe`, `extest_mode` and `q_hiz_req` are 0, and a data scan without an instruction load returns the identity value.
- R2: The controller follows the standard sixteen-state graph on each rising `tck`, with `tms` choosing the branch. Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state.
- R3: The scan path is chosen by opcode. Codes 000, 010 and 100 select the external chain (`bsr_tdo`), 001 selects the identity register, and 111 as well as the unused codes 011, 101 and 110 select the one-bit bypass stage.
- R4: Capture-IR loads the pattern 001 into the instruction shift stage, so the first three bits shifted out are 1, 0, 0.
- R5: The active instruction changes only when the controller leaves Update-IR, or while it is in Test-Logic-Reset. Shifting a new code leaves the flags untouched until Update-IR.
- R6: `q_hiz_req` is 1 exactly when opcode 010 is active, and `extest_mode` is 1 exactly when opcode 000 is active. Opcode 100 raises neither.
- R7: The bypass stage loads 0 in Capture-DR and takes `tdi` on each Shift-DR edge. It keeps its value through Exit1-DR, Pause-DR and Exit2-DR.
- R8: Under opcode 001, Capture-DR loads the 32-bit identity value (bit 0 is 1). The value shifts out LSB first while `tdi` enters at the top, so `tdi` data reappears after 32 shifts.
- R9: `tdo` and `tdo_oe` change on the falling edge of `tck`. `tdo_oe` is 1 only in Shift-DR and Shift-IR, and data leaves LSB first.
- R10: `bsr_capture`, `bsr_shift` and `bsr_update` are 1 only in Capture-DR, Shift-DR and Update-DR respectively, and only while an opcode that selects the external chain is active.
- R11: Each rising edge in Test-Logic-Reset reloads opcode 001 into the active instruction, dropping any earlier instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| pwr_rst_n | input | 1 | Power-up reset, active low, asynchronous |
| tms | input | 1 | Mode select that steers the controller |
| tdi | input | 1 | Serial data in |
| bsr_tdo | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` |
| bsr_capture | output | 1 | External chain: parallel capture strobe |
| bsr_shift | output | 1 | External chain: shift strobe |
| bsr_update | output | 1 | External chain: update strobe |
| extest_mode | output | 1 | External-test instruction active |
| q_hiz_req | output | 1 | Request to float the device's data outputs |

## Verification
The bench loads each of the eight opcodes and runs a 40-bit data scan under each one. A wrong decode of a reserved code, or a float request raised by plain sampling, shows up as a scan of the wrong length or a flag at the wrong level. Separate tests escape from the middle of Shift-DR with the mode line held high, and change the instruction shift stage while the old instruction must stay in force. A design that lost the instruction reset would keep the external-test flag raised. One that applied the instruction early would drop the float request before Update-IR. A further test parks the bypass stage in Pause-DR, where a design that cleared or shifted it there would return the wrong bit on resuming.

// File: rtl/tap_pkg.sv
package tap_pkg;

  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] { PATH_BSR, PATH_ID, PATH_BYP } path_e;

  function automatic tap_state_e tap_next(tap_state_e s, logic m);
    case (s)
      ST_TLR:    return m ? ST_TLR    : ST_RTI;
      ST_RTI:    return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: return m ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  return m ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: return m ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: return m ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  return m ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: return m ? ST_SEL_DR : ST_RTI;
      default:   return ST_TLR;
    endcase
  endfunction

  function automatic path_e path_of(logic [IR_W-1:0] op);
    case (op)
      OP_EXTEST, OP_SAMPLEZ, OP_SAMPLE: return PATH_BSR;
      OP_IDCODE:                        return PATH_ID;
      default:                          return PATH_BYP;
    endcase
  endfunction

  function automatic logic hiz_of(logic [IR_W-1:0] op);
    return op == OP_SAMPLEZ;
  endfunction

  function automatic logic extest_of(logic [IR_W-1:0] op);
    return op == OP_EXTEST;
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state_q
);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state_q <= ST_TLR;
    else        state_q <= tap_next(state_q, tms);
  end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_pkg::*;
#(
  parameter logic [IR_W-1:0] CAP_PAT  = IR_CAPTURE,
  parameter logic [IR_W-1:0] RESET_OP = OP_IDCODE
) (
  input  logic            tck,
  input  logic            rst_n,
  input  logic            tdi,
  input  logic            in_tlr,
  input  logic            in_cap,
  input  logic            in_shift,
  input  logic            in_upd,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_so
);

  logic [IR_W-1:0] sr_q;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= CAP_PAT;
      ir_q <= RESET_OP;
    end else begin
      if (in_cap)        sr_q <= CAP_PAT;
      else if (in_shift) sr_q <= {tdi, sr_q[IR_W-1:1]};
      if (in_tlr)        ir_q <= RESET_OP;
      else if (in_upd)   ir_q <= sr_q;
    end
  end

  assign ir_so = sr_q[0];

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import tap_pkg::*;
#(
  parameter int              ID_W   = 32,
  parameter logic [ID_W-1:0] ID_VAL = 32'h1A2B_3C4D | 32'h1
) (
  input  logic  tck,
  input  logic  rst_n,
  input  logic  tdi,
  input  path_e path,
  input  logic  in_cap,
  input  logic  in_shift,
  input  logic  bsr_so,
  output logic  byp_q,
  output logic  dr_so
);

  logic [ID_W-1:0] id_sr_q;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      byp_q   <= 1'b0;
      id_sr_q <= ID_VAL;
    end else begin
      if (path == PATH_BYP) begin
        if (in_cap)        byp_q <= 1'b0;
        else if (in_shift) byp_q <= tdi;
      end
      if (path == PATH_ID) begin
        if (in_cap)        id_sr_q <= ID_VAL;
        else if (in_shift) id_sr_q <= {tdi, id_sr_q[ID_W-1:1]};
      end
    end
  end

  always_comb begin
    case (path)
      PATH_BSR: dr_so = bsr_so;
      PATH_ID:  dr_so = id_sr_q[0];
      default:  dr_so = byp_q;
    endcase
  end

endmodule

// File: rtl/tap_top.sv
module tap_top
  import tap_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h5D3C_9A27
) (
  input  logic tck,
  input  logic pwr_rst_n,
  input  logic tms,
  input  logic tdi,
  input  logic bsr_tdo,
  output logic tdo,
  output logic tdo_oe,
  output logic bsr_capture,
  output logic bsr_shift,
  output logic bsr_update,
  output logic extest_mode,
  output logic q_hiz_req
);

  tap_state_e      state_q;
  logic [IR_W-1:0] ir_q;
  logic            ir_so;
  logic            dr_so;
  logic            byp_q;
  path_e           path;

  // Named state events, also observed by the checker.
  logic in_tlr, cap_dr, sh_dr, upd_dr, cap_ir, sh_ir, upd_ir;
  assign in_tlr = state_q == ST_TLR;
  assign cap_dr = state_q == ST_CAP_DR;
  assign sh_dr  = state_q == ST_SH_DR;
  assign upd_dr = state_q == ST_UPD_DR;
  assign cap_ir = state_q == ST_CAP_IR;
  assign sh_ir  = state_q == ST_SH_IR;
  assign upd_ir = state_q == ST_UPD_IR;

  tap_fsm u_fsm (
    .tck     (tck),
    .rst_n   (pwr_rst_n),
    .tms     (tms),
    .state_q (state_q)
  );

  tap_ir u_ir (
    .tck      (tck),
    .rst_n    (pwr_rst_n),
    .tdi      (tdi),
    .in_tlr   (in_tlr),
    .in_cap   (cap_ir),
    .in_shift (sh_ir),
    .in_upd   (upd_ir),
    .ir_q     (ir_q),
    .ir_so    (ir_so)
  );

  assign path = path_of(ir_q);

  tap_dr #(.ID_W(ID_W), .ID_VAL(ID_VALUE)) u_dr (
    .tck      (tck),
    .rst_n    (pwr_rst_n),
    .tdi      (tdi),
    .path     (path),
    .in_cap   (cap_dr),
    .in_shift (sh_dr),
    .bsr_so   (bsr_tdo),
    .byp_q    (byp_q),
    .dr_so    (dr_so)
  );

  logic bsr_sel;
  assign bsr_sel     = path == PATH_BSR;
  assign bsr_capture = bsr_sel && cap_dr;
  assign bsr_shift   = bsr_sel && sh_dr;
  assign bsr_update  = bsr_sel && upd_dr;
  assign extest_mode = extest_of(ir_q);
  assign q_hiz_req   = hiz_of(ir_q);

  always_ff @(negedge tck or negedge pwr_rst_n) begin
    if (!pwr_rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= sh_ir ? ir_so : dr_so;
      tdo_oe <= sh_ir || sh_dr;
    end
  end

endmodule

// File: rtl/tap_top_chk.sv
module tap_top_chk
  import tap_pkg::*;
(
  input logic            tck,
  input logic            pwr_rst_n,
  input logic            tms,
  input logic            tdo_oe,
  input logic            bsr_capture,
  input logic            bsr_shift,
  input logic            bsr_update,
  input logic            extest_mode,
  input logic            q_hiz_req,
  input tap_state_e      state_q,
  input logic [IR_W-1:0] ir_q,
  input logic            byp_q,
  input path_e           path
);

  logic [2:0] ones_q;
  always_ff @(posedge tck or negedge pwr_rst_n) begin
    if (!pwr_rst_n)      ones_q <= 3'd0;
    else if (!tms)       ones_q <= 3'd0;
    else if (ones_q < 5) ones_q <= ones_q + 3'd1;
  end

  a_r2_five_tms_reach_tlr: assert property (@(posedge tck) disable iff (!pwr_rst_n)
    (ones_q == 3'd5) |-> (state_q == ST_TLR));

  a_r9_oe_only_in_shift: assert property (@(posedge tck) disable iff (!pwr_rst_n)
    tdo_oe |-> (state_q == ST_SH_DR || state_q == ST_SH_IR));

  a_r11_tlr_loads_idcode: assert property (@(posedge tck) disable iff (!pwr_rst_n)
    (state_q == ST_TLR) |=> (ir_q == OP_IDCODE));

  a_r5_ir_held_outside_update: assert property (@(posedge tck) disable iff (!pwr_rst_n)
    (state_q != ST_UPD_IR && state_q != ST_TLR) |=> $stable(ir_q));

  a_r6_flags_exclusive: assert property (@(posedge tck) disable iff (!pwr_rst_n)
    $onehot0({q_hiz_req, extest_mode}));

  a_r10_strobes_in_state: assert property (@(posedge tck) disable iff (!pwr_rst_n)
    (bsr_capture || bsr_shift || bsr_update) |->
      ($onehot0({bsr_capture, bsr_shift, bsr_update}) &&
       (state_q == ST_CAP_DR || state_q == ST_SH_DR || state_q == ST_UPD_DR)));

  a_r7_bypass_captures_zero: assert property (@(posedge tck) disable iff (!pwr_rst_n)
    (state_q == ST_CAP_DR && path == PATH_BYP) |=> !byp_q);

  a_r7_bypass_held_in_pause: assert property (@(posedge tck) disable iff (!pwr_rst_n)
    (state_q == ST_PA_DR) |=> $stable(byp_q));

endmodule

bind tap_top tap_top_chk u_chk (
  .tck         (tck),
  .pwr_rst_n   (pwr_rst_n),
  .tms         (tms),
  .tdo_oe      (tdo_oe),
  .bsr_capture (bsr_capture),
  .bsr_shift   (bsr_shift),
  .bsr_update  (bsr_update),
  .extest_mode (extest_mode),
  .q_hiz_req   (q_hiz_req),
  .state_q     (state_q),
  .ir_q        (ir_q),
  .byp_q       (byp_q),
  .path        (path)
);

// File: tb/tb_tap_top.sv
module tb_tap_top;

  localparam int          BSR_LEN = 8;
  localparam logic [31:0] ID_VAL  = 32'h5D3C_9A27;
  localparam logic [7:0]  PINS    = 8'hA5;
  localparam int          NBITS   = 40;
  localparam logic [39:0] DIN     = 40'hC3_5A96_0F1E;

  // {opcode[6:4], kind[3:2] (0 chain,1 id,2 bypass), hiz[1], extest[0]}
  localparam logic [6:0] VEC [8] = '{
    {3'b000, 2'd0, 1'b0, 1'b1},
    {3'b001, 2'd1, 1'b0, 1'b0},
    {3'b010, 2'd0, 1'b1, 1'b0},
    {3'b011, 2'd2, 1'b0, 1'b0},
    {3'b100, 2'd0, 1'b0, 1'b0},
    {3'b101, 2'd2, 1'b0, 1'b0},
    {3'b110, 2'd2, 1'b0, 1'b0},
    {3'b111, 2'd2, 1'b0, 1'b0}
  };

  logic tck = 1'b0;
  logic pwr_rst_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b1;
  logic bsr_tdo;
  logic tdo, tdo_oe, bsr_capture, bsr_shift, bsr_update, extest_mode, q_hiz_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 tck = ~tck;

  tap_top #(.ID_W(32), .ID_VALUE(ID_VAL)) dut (
    .tck(tck), .pwr_rst_n(pwr_rst_n), .tms(tms), .tdi(tdi), .bsr_tdo(bsr_tdo),
    .tdo(tdo), .tdo_oe(tdo_oe), .bsr_capture(bsr_capture), .bsr_shift(bsr_shift),
    .bsr_update(bsr_update), .extest_mode(extest_mode), .q_hiz_req(q_hiz_req)
  );

  // External boundary chain model
  logic [BSR_LEN-1:0] chain = '0;
  logic [BSR_LEN-1:0] upd = '0;
  always @(posedge tck) begin
    if (bsr_capture)    chain <= PINS;
    else if (bsr_shift) chain <= {tdi, chain[BSR_LEN-1:1]};
    if (bsr_update)     upd <= chain;
  end
  assign bsr_tdo = chain[0];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  // From Run-Test/Idle: load an opcode, return captured bits, end in Run-Test/Idle.
  task automatic load_ir(input logic [2:0] op, output logic [2:0] cap);
    step(1, 1); step(1, 1); step(0, 1); step(0, 1);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo;
      step(i == 2, op[i]);
    end
    step(1, 1);
    step(0, 1);
  endtask

  // From Run-Test/Idle: scan n bits through the selected data register.
  task automatic scan_dr(input int n, input logic [63:0] din,
                         output logic [63:0] dout, output logic oe_seen);
    dout = '0;
    step(1, 1); step(0, 1); step(0, 1);
    oe_seen = tdo_oe;
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      step(i == n - 1, din[i]);
    end
    step(1, 1);
    step(0, 1);
  endtask

  function automatic logic [63:0] expect_scan(input logic [1:0] kind, input logic [63:0] din);
    logic [63:0] m;
    m = (64'd1 << NBITS) - 64'd1;
    case (kind)
      2'd0:    return ({56'd0, PINS} | (din << BSR_LEN)) & m;
      2'd1:    return ({32'd0, ID_VAL} | (din << 32)) & m;
      default: return (din << 1) & m;
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge tck);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] dout;
    logic [2:0]  cap;
    logic        oe;
    logic [7:0]  upd_before;

    // R1: reset state
    @(negedge tck); @(negedge tck); #1;
    chk("R1 oe in reset", {63'd0, tdo_oe}, 64'd0);
    chk("R1 flags in reset", {62'd0, q_hiz_req, extest_mode}, 64'd0);
    pwr_rst_n = 1'b1;
    step(1, 1);
    step(0, 1);
    chk("R1 oe idle", {63'd0, tdo_oe}, 64'd0);
    scan_dr(NBITS, {24'd0, DIN}, dout, oe);
    chk("R1 R8 identity after reset", dout, expect_scan(2'd1, {24'd0, DIN}));
    chk("R9 oe in shift", {63'd0, oe}, 64'd1);
    chk("R9 oe after scan", {63'd0, tdo_oe}, 64'd0);

    // Table: every opcode
    for (int v = 0; v < 8; v++) begin
      logic [2:0] op;
      logic [1:0] kind;
      op = VEC[v][6:4];
      kind = VEC[v][3:2];
      load_ir(op, cap);
      chk("R4 capture-ir pattern", {61'd0, cap}, 64'd1);
      chk("R6 hiz flag", {63'd0, q_hiz_req}, {63'd0, VEC[v][1]});
      chk("R6 extest flag", {63'd0, extest_mode}, {63'd0, VEC[v][0]});
      upd_before = upd;
      scan_dr(NBITS, {24'd0, DIN}, dout, oe);
      chk("R3 path by opcode", dout, expect_scan(kind, {24'd0, DIN}));
      if (kind == 2'd0)
        chk("R10 chain update", {56'd0, upd}, {56'd0, DIN[39:32]});
      else
        chk("R10 chain untouched", {56'd0, upd}, {56'd0, upd_before});
    end

    // R5: new code shifted, old one stays until Update-IR
    load_ir(3'b010, cap);
    step(1, 1); step(1, 1); step(0, 1); step(0, 1);
    step(0, 0); step(0, 0); step(1, 0);
    chk("R5 hiz held before update", {62'd0, q_hiz_req, extest_mode}, 64'd2);
    step(1, 1);
    chk("R5 hiz held in update-ir", {62'd0, q_hiz_req, extest_mode}, 64'd2);
    step(0, 1);
    chk("R5 new code after update", {62'd0, q_hiz_req, extest_mode}, 64'd1);

    // R2 R11: escape from Shift-DR with five TMS high
    step(1, 1); step(0, 1); step(0, 1);
    for (int i = 0; i < 5; i++) step(1, 1);
    step(1, 1);
    chk("R11 extest dropped in reset", {63'd0, extest_mode}, 64'd0);
    chk("R2 oe off in reset", {63'd0, tdo_oe}, 64'd0);
    step(0, 1);
    scan_dr(NBITS, {24'd0, DIN}, dout, oe);
    chk("R2 R11 identity after escape", dout, expect_scan(2'd1, {24'd0, DIN}));

    // R7: bypass keeps value through pause
    load_ir(3'b111, cap);
    step(1, 1); step(0, 1); step(0, 0);
    chk("R7 bypass captures zero", {63'd0, tdo}, 64'd0);
    step(1, 1);
    step(0, 0);
    chk("R9 oe off in pause", {63'd0, tdo_oe}, 64'd0);
    step(0, 0); step(1, 0); step(0, 0);
    chk("R7 bypass held through pause", {63'd0, tdo}, 64'd1);
    chk("R9 oe on again", {63'd0, tdo_oe}, 64'd1);
    step(1, 0); step(1, 1); step(0, 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule